// File: doc/BRIEF.md
# Software-Pipelined Loop Branch Controller

This block closes a counted loop that a compiler has turned into a software pipeline. It keeps two down-counters: a trip counter for the kernel iterations that are still to start, and a drain counter for the stages that must still empty once no new iterations start. Each time the loop-closing branch executes, the block decides whether to branch back. It updates the counters, raises a rotate strobe and supplies the bit that enters the lowest stage predicate.

The stage predicates are a 48-entry shift chain. Entry 0 gates the first pipeline stage, entry 1 the second, and so on. While the trip counter is nonzero, every rotation shifts a 1 into entry 0, so the stages switch on one at a time during the prolog and all stay on in the kernel. After the trip counter reaches zero, each rotation shifts in a 0, so the stages drain one at a time in the epilog. A rotating-base offset counts down by one on each rotation so that register renaming can follow.

Software prepares a loop in three steps. It pulses the setup input, which clears the chain and sets entry 0. It loads the trip counter with the iteration count minus one. It loads the drain counter with the number of stages.

Top module: `swp_loop_branch`

## Requirements
- R1: After reset the trip counter, the drain counter, every stage predicate and the rotating base are 0, and taken, rotate and inject_bit are low.
- R2: A high trip_load (or drain_load) writes trip_in (or drain_in) into its counter at the next rising edge. A high stage_setup makes the chain read 1 in entry 0 and 0 in all other entries after that edge. The three setup inputs act independently of each other.
- R3: When br_exec is high and the trip counter is nonzero, taken, rotate and inject_bit are all high in that cycle. At the edge the trip counter decrements by 1 and the drain counter holds.
- R4: When br_exec is high, the trip counter is 0 and the drain counter is greater than 1, taken and rotate are high and inject_bit is low. At the edge the drain counter decrements by 1.
- R5: When br_exec is high, the trip counter is 0 and the drain counter equals 1, rotate is high while taken and inject_bit are low. At the edge the drain counter becomes 0.
- R6: When br_exec is high and both counters are 0, taken, rotate and inject_bit stay low, and the counters, chain and rotating base keep their values.
- R7: At each rotation the chain shifts upward by one entry. Entry 0 takes inject_bit and the old entry 47 is discarded. The rotating base decrements by 1 modulo 2^RB_W (7 bits by default).
- R8: When br_exec is high in a cycle where trip_load, drain_load or stage_setup is also high, the branch is ignored. Taken, rotate and inject_bit stay low, the rotating base holds, and only the requested loads take effect.
- R9: When br_exec is low, taken, rotate and inject_bit are low, and the counters, chain and rotating base change only through the loads in R2.
- R10: After setup with trip 4 and drain 3, eight branch executions behave as follows. Five of them find chain entry 2 (the third stage) set. Seven of them rotate, and the first six are taken. The loop ends with the drain counter at 0 and the rotating base at 121 (that is, minus 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_load | input | 1 | Load the trip counter from trip_in |
| trip_in | input | LC_W | Trip counter load value |
| drain_load | input | 1 | Load the drain counter from drain_in |
| drain_in | input | EC_W | Drain counter load value |
| stage_setup | input | 1 | Clear the chain and set entry 0 |
| br_exec | input | 1 | Loop-closing branch executes this cycle |
| taken | output | 1 | Branch goes back to the loop top |
| rotate | output | 1 | Rotation strobe for registers and predicates |
| inject_bit | output | 1 | Value entering stage predicate entry 0 |
| trip_cnt | output | LC_W | Current trip counter |
| drain_cnt | output | EC_W | Current drain counter |
| stage_pred | output | PRED_N | Stage predicate chain, entry 0 first |
| rot_base | output | RB_W | Rotating base offset |

## Verification
The bench aims at the transitions between phases. These are the last kernel branch where the trip counter goes from 1 to 0, the drain counter going from 2 to 1, and the final branch with a drain count of 1, which must rotate without branching. A design that compared the drain counter against 0 rather than 1 would take one extra branch. A design that skipped the final rotation would leave the base at minus 6. A branch executed with both counters at zero must leave everything unchanged, and a branch arriving together with a load must lose to the load; a wrong priority shows up as a counter one below its loaded value. Long runs push 1s out past entry 47 and wrap the rotating base, which exposes shift direction and width errors.

// File: rtl/swp_loop_branch.sv
module swp_loop_branch #(
  parameter int LC_W   = 16,
  parameter int EC_W   = 6,
  parameter int PRED_N = 48,
  parameter int RB_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trip_load,
  input  logic [LC_W-1:0]   trip_in,
  input  logic              drain_load,
  input  logic [EC_W-1:0]   drain_in,
  input  logic              stage_setup,
  input  logic              br_exec,
  output logic              taken,
  output logic              rotate,
  output logic              inject_bit,
  output logic [LC_W-1:0]   trip_cnt,
  output logic [EC_W-1:0]   drain_cnt,
  output logic [PRED_N-1:0] stage_pred,
  output logic [RB_W-1:0]   rot_base
);

  logic any_setup, go, trip_nz, drain_nz, drain_gt1;

  assign any_setup  = trip_load | drain_load | stage_setup;
  assign go         = br_exec & ~any_setup;
  assign trip_nz    = |trip_cnt;
  assign drain_nz   = |drain_cnt;
  assign drain_gt1  = drain_cnt > EC_W'(1);

  assign inject_bit = go & trip_nz;
  assign rotate     = go & (trip_nz | drain_nz);
  assign taken      = go & (trip_nz | drain_gt1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trip_cnt <= '0;
    else if (trip_load)
      trip_cnt <= trip_in;
    else if (go && trip_nz)
      trip_cnt <= trip_cnt - LC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      drain_cnt <= '0;
    else if (drain_load)
      drain_cnt <= drain_in;
    else if (go && !trip_nz && drain_nz)
      drain_cnt <= drain_cnt - EC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stage_pred <= '0;
    else if (stage_setup)
      stage_pred <= PRED_N'(1);
    else if (rotate)
      stage_pred <= {stage_pred[PRED_N-2:0], inject_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rot_base <= '0;
    else if (rotate)
      rot_base <= rot_base - RB_W'(1);
  end

endmodule

// File: rtl/swp_loop_branch_chk.sv
module swp_loop_branch_chk #(
  parameter int LC_W   = 16,
  parameter int EC_W   = 6,
  parameter int PRED_N = 48,
  parameter int RB_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trip_load,
  input logic              drain_load,
  input logic              stage_setup,
  input logic              br_exec,
  input logic              taken,
  input logic              rotate,
  input logic              inject_bit,
  input logic [LC_W-1:0]   trip_cnt,
  input logic [EC_W-1:0]   drain_cnt,
  input logic [PRED_N-1:0] stage_pred,
  input logic [RB_W-1:0]   rot_base
);

  a_r3_trip_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && inject_bit) |=> (trip_cnt == LC_W'($past(trip_cnt) - 1'b1)));

  a_r4_taken_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> rotate);

  a_r5_last_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !taken) |=> (drain_cnt == '0));

  a_r6_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_cnt == '0 && drain_cnt == '0) |-> (!rotate && !taken && !inject_bit));

  a_r7_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> (stage_pred[0] == $past(inject_bit) &&
                stage_pred[PRED_N-1:1] == $past(stage_pred[PRED_N-2:0])));

  a_r7_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> (rot_base == RB_W'($past(rot_base) - 1'b1)));

  a_r8_setup_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_load || drain_load || stage_setup) |-> (!rotate && !taken));

  a_r9_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
    !br_exec |-> (!rotate && !taken && !inject_bit));

  a_r9_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rotate |=> $stable(rot_base));

endmodule

bind swp_loop_branch swp_loop_branch_chk #(
  .LC_W(LC_W), .EC_W(EC_W), .PRED_N(PRED_N), .RB_W(RB_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trip_load(trip_load), .drain_load(drain_load),
  .stage_setup(stage_setup), .br_exec(br_exec), .taken(taken), .rotate(rotate),
  .inject_bit(inject_bit), .trip_cnt(trip_cnt), .drain_cnt(drain_cnt),
  .stage_pred(stage_pred), .rot_base(rot_base)
);

// File: tb/swp_loop_branch_tb.sv
module swp_loop_branch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LC_W = 16, EC_W = 6, PRED_N = 48, RB_W = 7;

  logic clk = 0, rst_n = 0;
  logic trip_load = 0, drain_load = 0, stage_setup = 0, br_exec = 0;
  logic [LC_W-1:0] trip_in = '0;
  logic [EC_W-1:0] drain_in = '0;
  logic taken, rotate, inject_bit;
  logic [LC_W-1:0] trip_cnt;
  logic [EC_W-1:0] drain_cnt;
  logic [PRED_N-1:0] stage_pred;
  logic [RB_W-1:0] rot_base;

  integer vectors = 0, fails = 0, stores = 0, rotations = 0, takens = 0;
  integer m_trip = 0, m_drain = 0, m_base = 0;
  logic [PRED_N-1:0] m_pred = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swp_loop_branch #(.LC_W(LC_W), .EC_W(EC_W), .PRED_N(PRED_N), .RB_W(RB_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .trip_load(trip_load), .trip_in(trip_in),
    .drain_load(drain_load), .drain_in(drain_in), .stage_setup(stage_setup),
    .br_exec(br_exec), .taken(taken), .rotate(rotate), .inject_bit(inject_bit),
    .trip_cnt(trip_cnt), .drain_cnt(drain_cnt), .stage_pred(stage_pred),
    .rot_base(rot_base));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // one cycle: drive, compare against the reference, advance the reference
  task automatic step(input logic br, input logic tl, input int tv,
                      input logic dl, input int dv, input logic ss);
    string req;
    logic e_take, e_rot, e_inj, busy;
    @(negedge clk);
    br_exec = br; trip_load = tl; trip_in = LC_W'(tv);
    drain_load = dl; drain_in = EC_W'(dv); stage_setup = ss;
    #1;
    busy = tl | dl | ss;
    e_take = 0; e_rot = 0; e_inj = 0;
    if (br && busy) req = "R8";
    else if (br && m_trip != 0) begin req = "R3"; e_take = 1; e_rot = 1; e_inj = 1; end
    else if (br && m_drain > 1) begin req = "R4"; e_take = 1; e_rot = 1; end
    else if (br && m_drain == 1) begin req = "R5"; e_rot = 1; end
    else if (br) req = "R6";
    else if (busy) req = "R2";
    else req = "R9";
    check(req, "trip_cnt", trip_cnt, m_trip);
    check(req, "drain_cnt", drain_cnt, m_drain);
    check({req, "/R7"}, "rot_base", rot_base, m_base);
    check({req, "/R7"}, "stage_pred lo", stage_pred[31:0], m_pred[31:0]);
    check({req, "/R7"}, "stage_pred hi", stage_pred[PRED_N-1:32], m_pred[PRED_N-1:32]);
    check(req, "taken", taken, e_take);
    check(req, "rotate", rotate, e_rot);
    check(req, "inject_bit", inject_bit, e_inj);
    if (br && !busy && m_pred[2]) stores++;
    if (e_rot) begin
      rotations++;
      m_pred = {m_pred[PRED_N-2:0], e_inj};
      m_base = (m_base + (1 << RB_W) - 1) % (1 << RB_W);
    end
    if (e_take) takens++;
    if (e_inj) m_trip--;
    else if (e_rot) m_drain--;
    if (tl) m_trip = tv;
    if (dl) m_drain = dv;
    if (ss) m_pred = PRED_N'(1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1", "taken", taken, 0);
    check("R1", "rotate", rotate, 0);
    check("R1", "stage_pred", stage_pred[31:0], 0);
    check("R1", "rot_base", rot_base, 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0);
    // R6: branch with empty counters
    step(1, 0, 0, 0, 0, 0);
    // R2/R10: setup for 5 iterations, 3 stages
    step(0, 1, 4, 1, 3, 1);
    stores = 0; rotations = 0; takens = 0;
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0);
    check("R10", "stores", stores, 5);
    check("R10", "rotations", rotations, 7);
    check("R10", "taken count", takens, 6);
    check("R10", "drain_cnt", drain_cnt, 0);
    check("R10", "rot_base", rot_base, 121);
    // R8: branch together with each kind of load
    step(1, 1, 2, 0, 0, 0);
    step(1, 0, 0, 1, 2, 0);
    step(1, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    // run down with gaps (R9 between branches)
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
    end
    // R7: long run fills the chain and pushes 1s past the top, base wraps
    step(0, 1, 70, 1, 4, 1);
    for (int i = 0; i < 80; i++) step(1, 0, 0, 0, 0, 0);
    check("R7", "stage_pred top", stage_pred[PRED_N-1], 1);
    // R5: drain count of 1 only
    step(0, 1, 0, 1, 1, 0);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    // R3 with drain 0: trip alone still rotates
    step(0, 1, 2, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
    // max trip value
    step(0, 1, 65535, 1, 63, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
    summary();
  end
endmodule